// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between the host bus and the program/erase engine of a NOR-style flash device. It watches host write cycles and recognises single-cycle commands and two-cycle command pairs. The single-cycle commands select the read mode or clear the error flags. The two-cycle pairs are a setup write followed by a second write that supplies the operands. It also keeps the status byte that the host polls while an operation runs.

Before any operation starts, the block checks three things: the programming-voltage lockout input, the per-sector lock bits, and the write-protect pin for the boot sector. A check that fails sets its own cause flag together with the erase-fail or program-fail flag. An operation that passes all checks goes to the write engine as a request on a valid/ready channel. The request carries the operation kind, the sector number, the word address and the data. A read-mode output tells the array read path whether host reads should return memory contents or the status byte.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, `status_q` is 8'h80 (bit 7 = ready, all error bits 0), `rd_status` is 0 and `req_valid` is 0.
- R2: A write with low byte 20h followed by a write with low byte D0h raises `req_valid` with `req_op`=0 (erase). The request carries `req_sector` = the top SECT_W bits of the confirm write's address, and `req_addr` = that address. `status_q[7]` drops to 0 and `rd_status` becomes 1.
- R3: A write with low byte 40h, or the alternate 10h, followed by any write raises `req_valid` with `req_op`=1 (program). The request carries `req_addr` and `req_data` equal to the second write's address and data, and `req_sector` = the top SECT_W address bits.
- R4: If the write after 20h does not have low byte D0h, no request is made and `status_q` bits 5 and 4 are both set. That second write is not decoded as a command.
- R5: If `vpp_low` is 1 when an operation's second write arrives, no request is made. Bit 3 is set, together with bit 5 for an erase or bit 4 for a program.
- R6: If the target sector's bit in `sect_lock` is 1, no request is made. The same holds for a program to sector BOOT_SECT while `wp_n` is 0, but not for an erase of that sector. In these cases bit 1 is set, together with bit 5 for an erase or bit 4 for a program. When both the voltage and the lock checks fail, bits 3 and 1 are both set.
- R7: Writing 70h sets `rd_status` to 1. Writing FFh sets it to 0. Codes that are not commands leave it unchanged.
- R8: Error bits 5, 4, 3 and 1 stay set across later operations until the clear opcode (CLR_CODE, default 5Ah) is written, which zeroes all four.
- R9: While `status_q[7]` is 0, all writes are ignored except the suspend code (SUSP_CODE, default 50h). That code produces a one-cycle pulse on `susp_req` and has no effect while idle.
- R10: The request fields stay stable while `req_valid` is 1 and `req_ready` is 0. `req_valid` falls in the cycle after a handshake. `status_q[7]` returns to 1 in the cycle after `eng_done`. If `eng_fail` is 1 with `eng_done`, bit 5 (erase) or bit 4 (program) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Host write address |
| bus_wdata | input | DATA_W | Host write data; low byte is the command code |
| vpp_low | input | 1 | Programming voltage below lockout level |
| wp_n | input | 1 | Write-protect pin, low protects the boot sector from programming |
| sect_lock | input | NSECT | Per-sector lock bits |
| rd_status | output | 1 | 1: reads return status; 0: reads return array data |
| status_q | output | 8 | Status byte |
| req_valid | output | 1 | Operation request valid |
| req_ready | input | 1 | Engine accepts the request |
| req_op | output | 1 | 0 erase, 1 program |
| req_sector | output | SECT_W | Target sector |
| req_addr | output | ADDR_W | Target word address |
| req_data | output | DATA_W | Program data |
| eng_done | input | 1 | Engine finished, one-cycle pulse |
| eng_fail | input | 1 | Engine verify failed, valid with eng_done |
| susp_req | output | 1 | One-cycle suspend request to the engine |

Back-pressure rule: once raised, `req_valid` stays high with unchanged fields until a cycle in which `req_ready` is 1. No new request can be raised before `eng_done`.

## Verification
The bench targets these corner cases:
- A broken erase pair whose second code is 70h. A design that treats that code as a command would enter status mode without flagging the bad sequence.
- An erase of the boot sector while `wp_n` is low. A design that applies the pin to erases would wrongly reject it.
- A setup code written while busy, followed after completion by a data-like write. A decoder that remembers setups during busy would start a program.
- Error flags after a later successful operation. A design that clears them on success would lose the earlier failure before the clear command.
- A request held under back-pressure, to catch fields that change before the handshake.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic {OP_ERASE = 1'b0, OP_PROG = 1'b1} fcd_op_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ERS_SETUP = 2'd1, ST_PGM_SETUP = 2'd2} fcd_state_e;
  localparam int SR_READY = 7;
  localparam int SR_ERS   = 5;
  localparam int SR_PGM   = 4;
  localparam int SR_VPP   = 3;
  localparam int SR_LOCK  = 1;
endpackage

// File: rtl/fcd_decoder.sv
module fcd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [7:0] ERS_CODE = 8'h20,
  parameter logic [7:0] CNF_CODE = 8'hD0,
  parameter logic [7:0] PGM_CODE = 8'h40,
  parameter logic [7:0] PGM_ALT  = 8'h10,
  parameter logic [7:0] STAT_CODE = 8'h70,
  parameter logic [7:0] ARR_CODE = 8'hFF,
  parameter logic [7:0] CLR_CODE = 8'h5A,
  parameter logic [7:0] SUSP_CODE = 8'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  output logic              go,
  output fcd_op_e           go_op,
  output logic [ADDR_W-1:0] go_addr,
  output logic [DATA_W-1:0] go_data,
  output logic              seq_bad,
  output logic              mode_status,
  output logic              mode_array,
  output logic              clr,
  output logic              susp
);
  fcd_state_e state_q, state_d;
  logic [7:0] code;
  logic       act;

  assign code = wdata[7:0];
  assign act  = we && !busy;

  always_comb begin
    state_d     = state_q;
    go          = 1'b0;
    go_op       = OP_ERASE;
    go_addr     = addr;
    go_data     = wdata;
    seq_bad     = 1'b0;
    mode_status = 1'b0;
    mode_array  = 1'b0;
    clr         = 1'b0;
    susp        = we && busy && (code == SUSP_CODE);
    if (act) begin
      unique case (state_q)
        ST_IDLE: begin
          if (code == ERS_CODE) begin
            state_d     = ST_ERS_SETUP;
            mode_status = 1'b1;
          end else if (code == PGM_CODE || code == PGM_ALT) begin
            state_d     = ST_PGM_SETUP;
            mode_status = 1'b1;
          end else if (code == STAT_CODE) begin
            mode_status = 1'b1;
          end else if (code == ARR_CODE) begin
            mode_array = 1'b1;
          end else if (code == CLR_CODE) begin
            clr = 1'b1;
          end
        end
        ST_ERS_SETUP: begin
          state_d = ST_IDLE;
          go_op   = OP_ERASE;
          if (code == CNF_CODE) go = 1'b1;
          else                  seq_bad = 1'b1;
        end
        ST_PGM_SETUP: begin
          state_d = ST_IDLE;
          go_op   = OP_PROG;
          go      = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R9: nothing but the suspend pulse comes out while busy
  a_r9_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !go && !seq_bad && !clr && !mode_status && !mode_array);
  // R4: a bad sequence only ever follows the erase setup
  a_r4_bad_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    seq_bad |-> state_q == ST_ERS_SETUP);
endmodule

// File: rtl/fcd_guard.sv
module fcd_guard
  import fcd_pkg::*;
#(
  parameter int SECT_W = 3,
  parameter int NSECT = 1 << SECT_W,
  parameter int BOOT_SECT = 0
) (
  input  fcd_op_e           op,
  input  logic [SECT_W-1:0] sector,
  input  logic              vpp_low,
  input  logic              wp_n,
  input  logic [NSECT-1:0]  lock,
  output logic              rej_vpp,
  output logic              rej_lock
);
  logic boot_hit;
  assign boot_hit = (sector == SECT_W'(BOOT_SECT));
  assign rej_vpp  = vpp_low;
  assign rej_lock = lock[sector] || (op == OP_PROG && boot_hit && !wp_n);
endmodule

// File: rtl/fcd_status.sv
module fcd_status
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  fcd_op_e    go_op,
  input  logic       rej_vpp,
  input  logic       rej_lock,
  input  logic       seq_bad,
  input  logic       clr,
  input  logic       eng_done,
  input  logic       eng_fail,
  output logic       launch,
  output logic       busy,
  output logic [7:0] sr
);
  logic    ers_err, pgm_err, vpp_err, lock_err;
  fcd_op_e run_op;
  logic    rejected;

  assign rejected = go && (rej_vpp || rej_lock);
  assign launch   = go && !rej_vpp && !rej_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      run_op   <= OP_ERASE;
      ers_err  <= 1'b0;
      pgm_err  <= 1'b0;
      vpp_err  <= 1'b0;
      lock_err <= 1'b0;
    end else begin
      if (launch) begin
        busy   <= 1'b1;
        run_op <= go_op;
      end else if (eng_done) begin
        busy <= 1'b0;
      end
      if (clr) begin
        ers_err  <= 1'b0;
        pgm_err  <= 1'b0;
        vpp_err  <= 1'b0;
        lock_err <= 1'b0;
      end else begin
        if (seq_bad) begin
          ers_err <= 1'b1;
          pgm_err <= 1'b1;
        end
        if (rejected) begin
          if (go_op == OP_ERASE) ers_err <= 1'b1;
          else                   pgm_err <= 1'b1;
          if (rej_vpp)  vpp_err  <= 1'b1;
          if (rej_lock) lock_err <= 1'b1;
        end
        if (eng_done && busy && eng_fail) begin
          if (run_op == OP_ERASE) ers_err <= 1'b1;
          else                    pgm_err <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    sr           = 8'h00;
    sr[SR_READY] = !busy;
    sr[SR_ERS]   = ers_err;
    sr[SR_PGM]   = pgm_err;
    sr[SR_VPP]   = vpp_err;
    sr[SR_LOCK]  = lock_err;
  end

  // R4: a broken erase pair flags both fail bits
  a_r4_seq_bits: assert property (@(posedge clk) disable iff (!rst_n)
    seq_bad |=> sr[SR_ERS] && sr[SR_PGM]);
  // R5: voltage rejection never starts an operation
  a_r5_vpp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (go && rej_vpp) |=> sr[SR_VPP] && !busy);
  // R8: error flags only drop on the clear command
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sr[SR_LOCK] && !clr) |=> sr[SR_LOCK]);
  // R10: ready returns after the engine reports completion
  a_r10_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done) |=> sr[SR_READY]);
endmodule

// File: rtl/fcd_req_port.sv
module fcd_req_port
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  fcd_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              ready,
  output logic              valid,
  output fcd_op_e           q_op,
  output logic [SECT_W-1:0] q_sector,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      q_op   <= OP_ERASE;
      q_addr <= '0;
      q_data <= '0;
    end else if (launch) begin
      valid  <= 1'b1;
      q_op   <= op;
      q_addr <= addr;
      q_data <= data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  assign q_sector = q_addr[ADDR_W-1 -: SECT_W];

  // R10: a stalled request keeps its fields
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> valid && $stable(q_addr) && $stable(q_data) && $stable(q_op));
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int SECT_W = 3,
  parameter int BOOT_SECT = 0,
  parameter logic [7:0] CLR_CODE = 8'h5A,
  parameter logic [7:0] SUSP_CODE = 8'h50,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              vpp_low,
  input  logic              wp_n,
  input  logic [NSECT-1:0]  sect_lock,
  output logic              rd_status,
  output logic [7:0]        status_q,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_op,
  output logic [SECT_W-1:0] req_sector,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  input  logic              eng_done,
  input  logic              eng_fail,
  output logic              susp_req
);
  logic              go, seq_bad, mode_status, mode_array, clr, susp;
  fcd_op_e           go_op, q_op;
  logic [ADDR_W-1:0] go_addr;
  logic [DATA_W-1:0] go_data;
  logic              rej_vpp, rej_lock, launch, busy;

  fcd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLR_CODE(CLR_CODE), .SUSP_CODE(SUSP_CODE)) u_dec (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .busy(busy),
    .go(go), .go_op(go_op), .go_addr(go_addr), .go_data(go_data), .seq_bad(seq_bad),
    .mode_status(mode_status), .mode_array(mode_array), .clr(clr), .susp(susp));

  fcd_guard #(.SECT_W(SECT_W), .NSECT(NSECT), .BOOT_SECT(BOOT_SECT)) u_guard (
    .op(go_op), .sector(go_addr[ADDR_W-1 -: SECT_W]), .vpp_low(vpp_low), .wp_n(wp_n),
    .lock(sect_lock), .rej_vpp(rej_vpp), .rej_lock(rej_lock));

  fcd_status u_stat (
    .clk(clk), .rst_n(rst_n), .go(go), .go_op(go_op), .rej_vpp(rej_vpp), .rej_lock(rej_lock),
    .seq_bad(seq_bad), .clr(clr), .eng_done(eng_done), .eng_fail(eng_fail),
    .launch(launch), .busy(busy), .sr(status_q));

  fcd_req_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_req (
    .clk(clk), .rst_n(rst_n), .launch(launch), .op(go_op), .addr(go_addr), .data(go_data),
    .ready(req_ready), .valid(req_valid), .q_op(q_op), .q_sector(req_sector),
    .q_addr(req_addr), .q_data(req_data));

  assign req_op = (q_op == OP_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_status <= 1'b0;
      susp_req  <= 1'b0;
    end else begin
      susp_req <= susp;
      if (mode_array)                          rd_status <= 1'b0;
      else if (mode_status || go || seq_bad)   rd_status <= 1'b1;
    end
  end

  // R2: a pending request always shows busy
  a_r2_busy_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !status_q[SR_READY]);
  // R9: the suspend pulse is only issued for a write seen while busy
  a_r9_susp_busy: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> $past(busy));
  // R7: a launch switches reads to status
  a_r7_status_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> rd_status);
endmodule

// File: tb/flash_cmd_if_tb.sv
`timescale 1ns/1ps
module flash_cmd_if_tb;
  localparam int ADDR_W = 16, DATA_W = 16, SECT_W = 3, NSECT = 8;
  logic clk = 0, rst_n = 0;
  logic bus_we = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic vpp_low = 0, wp_n = 1, req_ready = 0, eng_done = 0, eng_fail = 0;
  logic [NSECT-1:0] sect_lock = '0;
  logic rd_status, req_valid, req_op, susp_req;
  logic [7:0] status_q;
  logic [SECT_W-1:0] req_sector;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  flash_cmd_if u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .vpp_low(vpp_low), .wp_n(wp_n), .sect_lock(sect_lock), .rd_status(rd_status),
    .status_q(status_q), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_sector(req_sector), .req_addr(req_addr), .req_data(req_data),
    .eng_done(eng_done), .eng_fail(eng_fail), .susp_req(susp_req));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic accept();
    @(negedge clk); req_ready = 1;
    @(negedge clk); req_ready = 0;
    chk("R10 valid drops after handshake", req_valid, 0);
  endtask

  task automatic finish_op(input logic fail);
    @(negedge clk); eng_done = 1; eng_fail = fail;
    @(negedge clk); eng_done = 0; eng_fail = 0;
    chk("R10 ready after done", status_q[7], 1);
  endtask

  task automatic t_reset();
    chk("R1 status", status_q, 8'h80);
    chk("R1 rd_status", rd_status, 0);
    chk("R1 req_valid", req_valid, 0);
  endtask

  task automatic t_erase_ok();
    wr(16'h6000, 16'h0020);
    wr(16'h6123, 16'h00D0);
    chk("R2 valid", req_valid, 1);
    chk("R2 op", req_op, 0);
    chk("R2 sector", req_sector, 3);
    chk("R2 addr", req_addr, 16'h6123);
    chk("R2 busy", status_q, 8'h00);
    chk("R2 rd_status", rd_status, 1);
    repeat (3) @(negedge clk);
    chk("R10 held valid", req_valid, 1);
    chk("R10 held addr", req_addr, 16'h6123);
    accept();
    finish_op(0);
    chk("R2 status after done", status_q, 8'h80);
  endtask

  task automatic t_program(input logic [7:0] setup);
    wr(16'h0000, {8'h00, setup});
    wr(16'h2345, 16'hBEEF);
    chk("R3 valid", req_valid, 1);
    chk("R3 op", req_op, 1);
    chk("R3 sector", req_sector, 1);
    chk("R3 addr", req_addr, 16'h2345);
    chk("R3 data", req_data, 16'hBEEF);
    accept();
    finish_op(0);
    chk("R3 status", status_q, 8'h80);
  endtask

  task automatic t_bad_seq();
    wr(16'h0000, 16'hFF);
    wr(16'h4000, 16'h20);
    wr(16'h4000, 16'h70);
    chk("R4 no request", req_valid, 0);
    chk("R4 bits", status_q, 8'hB0);
    wr(16'h0000, 16'hFF);
    wr(16'h0000, 16'h5A);
    chk("R8 cleared", status_q, 8'h80);
    chk("R7 array mode", rd_status, 0);
  endtask

  task automatic t_vpp();
    vpp_low = 1;
    wr(16'h6000, 16'h20); wr(16'h6000, 16'hD0);
    chk("R5 erase no request", req_valid, 0);
    chk("R5 erase bits", status_q, 8'hA8);
    wr(16'h0, 16'h5A);
    wr(16'h0, 16'h40); wr(16'h6000, 16'h1234);
    chk("R5 program bits", status_q, 8'h98);
    chk("R5 program no request", req_valid, 0);
    vpp_low = 0;
    wr(16'h0, 16'h5A);
  endtask

  task automatic t_lock();
    sect_lock = 8'b0010_0000;
    wr(16'hA000, 16'h20); wr(16'hA010, 16'hD0);
    chk("R6 erase lock bits", status_q, 8'hA2);
    wr(16'h0, 16'h5A);
    wr(16'h0, 16'h10); wr(16'hA010, 16'h5555);
    chk("R6 program lock bits", status_q, 8'h92);
    chk("R6 no request", req_valid, 0);
    wr(16'h0, 16'h40); wr(16'h2000, 16'h0001);
    chk("R6 other sector ok", req_valid, 1);
    accept();
    finish_op(0);
    chk("R8 sticky after success", status_q, 8'h92);
    vpp_low = 1;
    wr(16'h0, 16'h5A);
    wr(16'h0, 16'h40); wr(16'hA000, 16'h0);
    chk("R6 both causes", status_q, 8'h9A);
    vpp_low = 0; sect_lock = '0;
    wr(16'h0, 16'h5A);
    chk("R8 clear all", status_q, 8'h80);
  endtask

  task automatic t_wp();
    wp_n = 0;
    wr(16'h0, 16'h40); wr(16'h0100, 16'hAAAA);
    chk("R6 boot program blocked", status_q, 8'h92);
    chk("R6 boot no request", req_valid, 0);
    wr(16'h0, 16'h5A);
    wr(16'h0, 16'h20); wr(16'h0100, 16'hD0);
    chk("R6 boot erase allowed", req_valid, 1);
    accept();
    finish_op(0);
    wp_n = 1;
    chk("R6 boot erase status", status_q, 8'h80);
  endtask

  task automatic t_modes();
    wr(16'h0, 16'hFF);
    chk("R7 FF array", rd_status, 0);
    wr(16'h0, 16'h70);
    chk("R7 70 status", rd_status, 1);
    wr(16'h0, 16'h33);
    chk("R7 unknown keeps", rd_status, 1);
    wr(16'h0, 16'hFF);
    chk("R7 back to array", rd_status, 0);
    wr(16'h0, 16'h50);
    chk("R9 idle suspend no pulse", susp_req, 0);
  endtask

  task automatic t_busy();
    wr(16'h6000, 16'h20); wr(16'h6000, 16'hD0);
    wr(16'h0, 16'hFF);
    chk("R9 FF ignored busy", rd_status, 1);
    wr(16'h0, 16'h5A);
    wr(16'h0, 16'h40);
    @(negedge clk); bus_we = 1; bus_wdata = 16'h50;
    @(negedge clk); bus_we = 0;
    chk("R9 suspend pulse", susp_req, 1);
    @(negedge clk);
    chk("R9 pulse one cycle", susp_req, 0);
    accept();
    finish_op(0);
    wr(16'h3000, 16'h1234);
    chk("R9 setup ignored while busy", req_valid, 0);
    chk("R9 status unchanged", status_q, 8'h80);
  endtask

  task automatic t_fail();
    wr(16'h0, 16'h40); wr(16'h2000, 16'h7);
    accept();
    finish_op(1);
    chk("R10 program fail bit", status_q, 8'h90);
    wr(16'h0, 16'h5A);
    wr(16'h0, 16'h20); wr(16'h4000, 16'hD0);
    accept();
    finish_op(1);
    chk("R10 erase fail bit", status_q, 8'hA0);
    wr(16'h0, 16'h5A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_erase_ok();
    t_program(8'h40);
    t_program(8'h10);
    t_bad_seq();
    t_vpp();
    t_lock();
    t_wp();
    t_modes();
    t_busy();
    t_fail();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule